// File: doc/BRIEF.md
# Up-Counting Timer with Qualified Update Events

This block is a free-running up-counter with a clock prescaler and a programmable wrap limit. Software drives it through a small word-addressed register port. A counter tick happens once every (prescale value + 1) clocks while the counter runs. The counter climbs from 0 to the active reload limit, and the next tick returns it to 0. That wrap is an overflow.

An update event copies the buffered prescale and reload values into their active shadow copies. Three sources can produce an update event: an overflow, a software generate request, and a pulse on the slave reset input. Two control bits qualify these events. One bit suppresses the update events completely. The other bit chooses which sources may raise the sticky status flag. The flag drives the interrupt line, and the same qualifying event can also produce a one-cycle DMA request.

A one-pulse mode makes hardware clear the enable after the next update event. A trigger input can start the counter. A gate input can hold the counter while the enable stays set.

The enable is a three-state machine with these states:
- `ST_OFF`: stopped.
- `ST_RUN`: counting.
- `ST_PAUSE`: enabled, but the gate is closed.

It has these transitions:
- START: `ST_OFF` to `ST_RUN`, or to `ST_PAUSE` when the gate is closed. Caused by a software enable write or a qualified trigger edge.
- CLOSE: `ST_RUN` to `ST_PAUSE`, when gate mode is on and the gate is low.
- OPEN: `ST_PAUSE` to `ST_RUN`, when the gate is high or gate mode is off.
- ONESHOT: any state to `ST_OFF`, on an update event in one-pulse mode.
- STOP: any state to `ST_OFF`, on a software write that clears the enable.

A software write to the control register is applied after ONESHOT, so that write wins.

Top module: `upcount_timer`

## Requirements
- R1: After reset the values are as follows:
  - The control word (address 0) reads 0.
  - The counter (address 4) reads 0.
  - The status word (address 2) reads 0.
  - The prescale register (address 5) reads 0.
  - The reload register (address 6) reads 0xFFFF.
  - `upd_irq` and `upd_dma` are low.
- R2: The control word layout is fixed:
  - bit 0 is the enable,
  - bit 1 is update disable,
  - bit 2 is request source,
  - bit 3 is one-pulse,
  - bit 7 is reload buffering,
  - all other bits read 0.

  While the machine is in `ST_RUN`, the counter advances once every (active prescale + 1) clocks. It climbs to the active reload value, and the next tick wraps it to 0 as an overflow. In any other state, the counter holds its value.
- R3: When the active reload value is 0, the counter stays at 0 and no overflow happens.
- R4: When buffering is 0, a reload write (address 6) takes effect at once. When buffering is 1, the written value is held, reads back from address 6, and becomes active only at the next update event.
- R5: A prescale write (address 5) becomes active only at an update event.
- R6: Each of the following clears the counter and the prescale counter to 0 and, unless updates are disabled, causes an update event:
  - a write with bit 0 set to the generate register (address 3),
  - a one-cycle pulse on `slv_rst_in`.
- R7: When update disable is 1, the following hold:
  - no update event occurs from any source,
  - the shadow values stay unchanged,
  - the flag is not set,
  - the clearing of R6 still happens.
- R8: When request source is 0, every update event sets the flag. When it is 1, only an overflow sets the flag.
- R9: The status flag (address 2, bit 0) behaves as follows:
  - It is sticky.
  - Writing a 0 to it clears it, and a set in the same cycle wins over the clear.
  - `upd_irq` equals the flag AND the config bit 0 (address 1).
  - `upd_dma` pulses high for one cycle, after each flag-setting event, only when config bit 1 is set.
- R10: In one-pulse mode, an update event clears the enable, and the counter then stops.
- R11: The trigger and gate inputs work as follows:
  - When config bit 5 is set, a rising edge on `trig_in` sets the enable.
  - When config bit 4 is set, the counter advances only while `gate_in` is high and the enable is set.
- R12: Writes with `bus_size` 0 (byte) are ignored, and sizes 1 (half) and 2 (word) are accepted. A read returns the low 8 bits for size 0, the low 16 bits for size 1, and all 32 bits otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_addr | input | ADDR_W | Register word address |
| bus_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Combinational read data |
| trig_in | input | 1 | Trigger start input (rising edge) |
| gate_in | input | 1 | Count gate input |
| slv_rst_in | input | 1 | Slave reset/update pulse |
| upd_irq | output | 1 | Update interrupt level |
| upd_dma | output | 1 | Update DMA request pulse |

## Verification
The bench targets these corner cases, each paired with the fault it would expose:

| Corner case | What a wrong design would do |
|---|---|
| A buffered reload rewritten in the middle of a period | Apply it at once and cut the current period short |
| A prescale write left hanging while updates are disabled | Change the tick rate after a generate request |
| A generate request with request source 1 | Raise the flag |
| A zero reload limit | Let the counter wrap with false overflows |
| One-pulse mode | Keep counting after the first update |
| The gate, held low after a trigger start | Let counts leak through |

Byte writes are aimed at live registers, to catch a design that accepts narrow writes.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_PAUSE = 2'd2
    } run_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;

    localparam int A_CTRL = 0;
    localparam int A_CFG  = 1;
    localparam int A_STAT = 2;
    localparam int A_EVG  = 3;
    localparam int A_CNT  = 4;
    localparam int A_PSC  = 5;
    localparam int A_ARR  = 6;
endpackage

// File: rtl/tmr_run_fsm.sv
module tmr_run_fsm
    import tmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_start,
    input  logic sw_stop,
    input  logic trig_start,
    input  logic gate_mode,
    input  logic gate_in,
    input  logic opm_stop,
    output logic cen,
    output logic run
);
    run_state_e st, nxt, go_state;

    always_comb begin
        go_state = (gate_mode && !gate_in) ? ST_PAUSE : ST_RUN;
        nxt = st;
        unique case (st)
            ST_OFF:   if (sw_start || trig_start) nxt = go_state;         // START
            ST_RUN:   if (gate_mode && !gate_in) nxt = ST_PAUSE;          // CLOSE
            ST_PAUSE: if (!gate_mode || gate_in) nxt = ST_RUN;            // OPEN
            default:  nxt = ST_OFF;
        endcase
        if (opm_stop) nxt = ST_OFF;                                       // ONESHOT
        if (sw_stop) nxt = ST_OFF;                                        // STOP
        else if (sw_start && nxt == ST_OFF) nxt = go_state;               // software write wins
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= nxt;
    end

    always_comb begin
        cen = (st != ST_OFF);
        run = (st == ST_RUN);
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             reinit,
    input  logic             uev,
    input  logic             arpe,
    input  logic             cnt_wr,
    input  logic             psc_wr,
    input  logic             arr_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] psc_pre,
    output logic [CNT_W-1:0] psc_sh,
    output logic [CNT_W-1:0] arr_pre,
    output logic [CNT_W-1:0] arr_sh,
    output logic             ovf
);
    logic [CNT_W-1:0] pc;
    logic             tick, at_top;

    assign tick   = run && (pc == psc_sh);
    assign at_top = (arr_sh == '0) || (cnt >= arr_sh);
    assign ovf    = tick && (arr_sh != '0) && (cnt >= arr_sh);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc  <= '0;
            cnt <= '0;
        end else begin
            if (reinit)   pc <= '0;
            else if (run) pc <= tick ? '0 : pc + 1'b1;

            if (reinit)      cnt <= '0;
            else if (cnt_wr) cnt <= wdata;
            else if (tick)   cnt <= at_top ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            psc_pre <= '0;
            psc_sh  <= '0;
            arr_pre <= '1;
            arr_sh  <= '1;
        end else begin
            if (psc_wr) psc_pre <= wdata;
            if (uev)    psc_sh  <= psc_pre;
            if (arr_wr) arr_pre <= wdata;
            if (arr_wr && !arpe) arr_sh <= wdata;
            else if (uev)        arr_sh <= arr_pre;
        end
    end
endmodule

// File: rtl/upcount_timer.sv
module upcount_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              trig_in,
    input  logic              gate_in,
    input  logic              slv_rst_in,
    output logic              upd_irq,
    output logic              upd_dma
);
    localparam int HALF_W = (DATA_W < 16) ? DATA_W : 16;

    logic wr_ok, sel_ctrl, sel_cfg, sel_stat, sel_evg, sel_cnt, sel_psc, sel_arr;
    logic udis_q, urs_q, opm_q, arpe_q, irq_en_q, dma_en_q, gate_en_q, trg_en_q;
    logic flag_q, trig_q, reinit, uev, flag_set, ovf, cen, run, trig_start;
    logic [CNT_W-1:0]  cnt, psc_pre, psc_sh, arr_pre, arr_sh;
    logic [DATA_W-1:0] word;
    logic              unused_hi;

    assign wr_ok    = bus_wr && (bus_size != SZ_BYTE);
    assign sel_ctrl = wr_ok && (bus_addr == ADDR_W'(A_CTRL));
    assign sel_cfg  = wr_ok && (bus_addr == ADDR_W'(A_CFG));
    assign sel_stat = wr_ok && (bus_addr == ADDR_W'(A_STAT));
    assign sel_evg  = wr_ok && (bus_addr == ADDR_W'(A_EVG));
    assign sel_cnt  = wr_ok && (bus_addr == ADDR_W'(A_CNT));
    assign sel_psc  = wr_ok && (bus_addr == ADDR_W'(A_PSC));
    assign sel_arr  = wr_ok && (bus_addr == ADDR_W'(A_ARR));
    assign unused_hi = ^bus_wdata;

    assign reinit     = (sel_evg && bus_wdata[0]) || slv_rst_in;
    assign uev        = !udis_q && (reinit || ovf);
    assign flag_set   = uev && (ovf || !urs_q);
    assign trig_start = trg_en_q && trig_in && !trig_q;

    tmr_run_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_start   (sel_ctrl && bus_wdata[0]),
        .sw_stop    (sel_ctrl && !bus_wdata[0]),
        .trig_start (trig_start),
        .gate_mode  (gate_en_q),
        .gate_in    (gate_in),
        .opm_stop   (opm_q && uev),
        .cen        (cen),
        .run        (run)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .reinit  (reinit),
        .uev     (uev),
        .arpe    (arpe_q),
        .cnt_wr  (sel_cnt),
        .psc_wr  (sel_psc),
        .arr_wr  (sel_arr),
        .wdata   (bus_wdata[CNT_W-1:0]),
        .cnt     (cnt),
        .psc_pre (psc_pre),
        .psc_sh  (psc_sh),
        .arr_pre (arr_pre),
        .arr_sh  (arr_sh),
        .ovf     (ovf)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {udis_q, urs_q, opm_q, arpe_q} <= '0;
            {irq_en_q, dma_en_q, gate_en_q, trg_en_q} <= '0;
            flag_q  <= 1'b0;
            trig_q  <= 1'b0;
            upd_dma <= 1'b0;
        end else begin
            trig_q  <= trig_in;
            upd_dma <= flag_set && dma_en_q;
            if (sel_ctrl) begin
                udis_q <= bus_wdata[1];
                urs_q  <= bus_wdata[2];
                opm_q  <= bus_wdata[3];
                arpe_q <= bus_wdata[7];
            end
            if (sel_cfg) begin
                irq_en_q  <= bus_wdata[0];
                dma_en_q  <= bus_wdata[1];
                gate_en_q <= bus_wdata[4];
                trg_en_q  <= bus_wdata[5];
            end
            if (flag_set)                     flag_q <= 1'b1;
            else if (sel_stat && !bus_wdata[0]) flag_q <= 1'b0;
        end
    end

    assign upd_irq = flag_q && irq_en_q;

    always_comb begin
        word = '0;
        case (int'(bus_addr))
            A_CTRL:  word[7:0] = {arpe_q, 3'b000, opm_q, urs_q, udis_q, cen};
            A_CFG:   word[5:0] = {trg_en_q, gate_en_q, 2'b00, dma_en_q, irq_en_q};
            A_STAT:  word[0]   = flag_q;
            A_CNT:   word[CNT_W-1:0] = cnt;
            A_PSC:   word[CNT_W-1:0] = psc_pre;
            A_ARR:   word[CNT_W-1:0] = arr_pre;
            default: word = '0;
        endcase
        case (bus_size)
            2'd0:    bus_rdata = {{(DATA_W-8){1'b0}}, word[7:0]};
            2'd1:    bus_rdata = {{(DATA_W-HALF_W){1'b0}}, word[HALF_W-1:0]};
            default: bus_rdata = word;
        endcase
    end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             udis,
    input logic             urs,
    input logic             opm,
    input logic             dma_en,
    input logic             flag,
    input logic             ovf,
    input logic             uev,
    input logic             cen,
    input logic             ctrl_wr,
    input logic             cnt_wr,
    input logic             reinit,
    input logic             upd_dma,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] arr_sh,
    input logic [CNT_W-1:0] psc_sh
);
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !reinit && !cnt_wr) |=> (cnt == '0));

    p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen && !cnt_wr && !reinit) |=> $stable(cnt));

    p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_sh == '0 && cnt == '0 && !cnt_wr) |=> (cnt == '0));

    p_udis_shadow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        udis |=> $stable(psc_sh));

    p_urs_only_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (urs && !ovf && !flag) |=> !flag);

    p_dma_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_en |=> !upd_dma);

    p_opm_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (opm && uev && !ctrl_wr) |=> !cen);
endmodule

bind upcount_timer tmr_checker #(.CNT_W(CNT_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .udis    (udis_q),
    .urs     (urs_q),
    .opm     (opm_q),
    .dma_en  (dma_en_q),
    .flag    (flag_q),
    .ovf     (ovf),
    .uev     (uev),
    .cen     (cen),
    .ctrl_wr (sel_ctrl),
    .cnt_wr  (sel_cnt),
    .reinit  (reinit),
    .upd_dma (upd_dma),
    .cnt     (cnt),
    .arr_sh  (arr_sh),
    .psc_sh  (psc_sh)
);

// File: tb/tb_upcount_timer.sv
module tb_upcount_timer;
    localparam int CLK_P = 10;

    logic        clk = 0, rst_n = 0;
    logic        bus_wr = 0, trig_in = 0, gate_in = 0, slv_rst_in = 0;
    logic [2:0]  bus_addr = 0;
    logic [1:0]  bus_size = 2;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic        upd_irq, upd_dma;

    int n_chk = 0, n_err = 0;
    bit started = 0;

    always #(CLK_P/2) clk = ~clk;

    upcount_timer dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .trig_in(trig_in), .gate_in(gate_in), .slv_rst_in(slv_rst_in),
        .upd_irq(upd_irq), .upd_dma(upd_dma)
    );

    // behavioural reference model
    int m_st, m_cnt, m_pc, m_psc_pre, m_psc_sh, m_arr_pre, m_arr_sh;
    bit m_udis, m_urs, m_opm, m_arpe, m_ie, m_de, m_gm, m_tm, m_flag, m_dma, m_trig_q;
    bit wok, rin, tck, ovf, uev, fs, trs;
    int a, ns, go;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pc = 0; m_psc_pre = 0; m_psc_sh = 0;
            m_arr_pre = 65535; m_arr_sh = 65535;
            {m_udis, m_urs, m_opm, m_arpe, m_ie, m_de, m_gm, m_tm} = 0;
            m_flag = 0; m_dma = 0; m_trig_q = 0;
        end else begin
            a   = int'(bus_addr);
            wok = bus_wr && bus_size != 0;
            rin = (wok && a == 3 && bus_wdata[0]) || slv_rst_in;
            tck = (m_st == 1) && (m_pc == m_psc_sh);
            ovf = tck && m_arr_sh != 0 && m_cnt >= m_arr_sh;
            uev = !m_udis && (rin || ovf);
            fs  = uev && (ovf || !m_urs);
            trs = m_tm && trig_in && !m_trig_q;
            go  = (m_gm && !gate_in) ? 2 : 1;
            ns  = m_st;
            if (m_st == 0 && ((wok && a == 0 && bus_wdata[0]) || trs)) ns = go;
            else if (m_st == 1 && m_gm && !gate_in) ns = 2;
            else if (m_st == 2 && (!m_gm || gate_in)) ns = 1;
            if (m_opm && uev) ns = 0;
            if (wok && a == 0) begin
                if (!bus_wdata[0]) ns = 0;
                else if (ns == 0) ns = go;
            end
            // counter and prescale counter
            if (rin) m_pc = 0;
            else if (m_st == 1) m_pc = tck ? 0 : m_pc + 1;
            if (rin) m_cnt = 0;
            else if (wok && a == 4) m_cnt = int'(bus_wdata[15:0]);
            else if (tck) m_cnt = (m_arr_sh == 0 || m_cnt >= m_arr_sh) ? 0 : m_cnt + 1;
            // shadows before preloads and control change
            if (uev) m_psc_sh = m_psc_pre;
            if (wok && a == 6 && !m_arpe) m_arr_sh = int'(bus_wdata[15:0]);
            else if (uev) m_arr_sh = m_arr_pre;
            if (wok && a == 5) m_psc_pre = int'(bus_wdata[15:0]);
            if (wok && a == 6) m_arr_pre = int'(bus_wdata[15:0]);
            m_dma = fs && m_de;
            if (fs) m_flag = 1;
            else if (wok && a == 2 && !bus_wdata[0]) m_flag = 0;
            if (wok && a == 0) {m_arpe, m_opm, m_urs, m_udis} = {bus_wdata[7], bus_wdata[3:1]};
            if (wok && a == 1) {m_tm, m_gm, m_de, m_ie} = {bus_wdata[5:4], bus_wdata[1:0]};
            m_trig_q = trig_in;
            m_st = ns;
        end
    end

    function automatic logic [31:0] m_read(input int ad, input logic [1:0] sz);
        logic [31:0] v = 0;
        case (ad)
            0: v = {24'd0, m_arpe, 3'b000, m_opm, m_urs, m_udis, m_st != 0};
            1: v = {26'd0, m_tm, m_gm, 2'b00, m_de, m_ie};
            2: v = {31'd0, m_flag};
            4: v = m_cnt;
            5: v = m_psc_pre;
            6: v = m_arr_pre;
            default: v = 0;
        endcase
        if (sz == 0) v = v & 32'hFF;
        else if (sz == 1) v = v & 32'hFFFF;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // every clock: interrupt level and DMA pulse against the model (R9)
    always @(negedge clk) begin
        if (started && rst_n) begin
            chk("R9 irq level", {31'd0, upd_irq}, {31'd0, m_flag && m_ie});
            chk("R9 dma pulse", {31'd0, upd_dma}, {31'd0, m_dma});
        end
    end

    task automatic bus_write(input int ad, input logic [31:0] d, input logic [1:0] sz);
        bus_wr = 1; bus_addr = 3'(ad); bus_wdata = d; bus_size = sz;
        @(negedge clk);
        bus_wr = 0; bus_size = 2;
    endtask

    task automatic read_chk(input int ad, input logic [1:0] sz, input string tag);
        bus_addr = 3'(ad); bus_size = sz;
        #1;
        chk(tag, bus_rdata, m_read(ad, sz));
        bus_size = 2;
    endtask

    task automatic watch_cnt(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            read_chk(4, 2, tag);
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_err++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        started = 1;
        @(negedge clk);
        // R1 reset state
        read_chk(0, 2, "R1 ctrl reset");
        read_chk(4, 2, "R1 counter reset");
        read_chk(2, 2, "R1 status reset");
        read_chk(5, 2, "R1 prescale reset");
        read_chk(6, 2, "R1 reload reset");
        chk("R1 irq reset", {31'd0, upd_irq}, 32'd0);
        // R12 access sizes
        bus_write(5, 32'h5, 0);
        read_chk(5, 2, "R12 byte write ignored");
        read_chk(6, 0, "R12 byte read");
        read_chk(6, 1, "R12 half read");
        // setup: irq+dma on, prescale 2 (held, R5), reload 4 immediate (R4)
        bus_write(1, 32'h3, 2);
        bus_write(5, 32'h2, 1);
        bus_write(6, 32'h4, 2);
        read_chk(6, 2, "R4 immediate reload");
        bus_write(3, 32'h1, 2);
        read_chk(2, 2, "R6 generate sets flag");
        bus_write(2, 32'h0, 2);
        read_chk(2, 2, "R9 flag cleared by zero");
        bus_write(0, 32'hFF01, 2);
        read_chk(0, 2, "R2 reserved bits read zero");
        watch_cnt(20, "R2 divided count and wrap");
        read_chk(2, 2, "R9 flag sticky after overflow");
        // R4 buffered reload
        bus_write(0, 32'h81, 2);
        bus_write(6, 32'h7, 2);
        read_chk(6, 2, "R4 preload read back");
        watch_cnt(40, "R4 buffered reload takes effect at update");
        // R8 request source restricted
        bus_write(0, 32'h85, 2);
        bus_write(2, 32'h0, 2);
        bus_write(3, 32'h1, 2);
        read_chk(4, 2, "R6 generate clears counter");
        read_chk(2, 2, "R8 generate does not set flag");
        watch_cnt(30, "R8 overflow still counts");
        read_chk(2, 2, "R8 overflow sets flag");
        // R7 update disable
        bus_write(0, 32'h83, 2);
        bus_write(2, 32'h0, 2);
        bus_write(5, 32'h0, 2);
        bus_write(3, 32'h1, 2);
        read_chk(4, 2, "R7 reinit despite disable");
        watch_cnt(30, "R7 prescale shadow unchanged");
        read_chk(2, 2, "R7 no flag while disabled");
        // R6 slave reset input with updates enabled
        bus_write(0, 32'h01, 2);
        bus_write(2, 32'h0, 2);
        slv_rst_in = 1;
        @(negedge clk);
        slv_rst_in = 0;
        read_chk(2, 2, "R6 slave pulse sets flag");
        read_chk(4, 2, "R6 slave pulse clears counter");
        watch_cnt(10, "R5 new prescale active after update");
        // R3 zero reload
        bus_write(6, 32'h0, 2);
        bus_write(2, 32'h0, 2);
        watch_cnt(15, "R3 counter held at zero");
        read_chk(2, 2, "R3 no overflow flag");
        // R10 one-pulse
        bus_write(0, 32'h0, 2);
        bus_write(6, 32'h3, 2);
        bus_write(4, 32'h0, 2);
        bus_write(0, 32'h9, 2);
        watch_cnt(12, "R10 counter stops after one period");
        read_chk(0, 2, "R10 enable cleared");
        // R11 trigger and gate, dma disabled
        bus_write(1, 32'h31, 2);
        gate_in = 0;
        trig_in = 1;
        @(negedge clk);
        trig_in = 0;
        read_chk(0, 2, "R11 trigger sets enable");
        watch_cnt(6, "R11 gate closed holds counter");
        gate_in = 1;
        watch_cnt(10, "R11 gate open counts");
        // R12 byte write to control ignored
        bus_write(0, 32'h0, 0);
        read_chk(0, 2, "R12 byte write to control ignored");
        watch_cnt(3, "R12 still counting");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule